// File: doc/BRIEF.md
# Switch Fault Flag Logic

This block merges the load-current comparators and the die-temperature reading of a high-side switch driver into one registered, active-low fault flag. It also produces the thermal-shutdown request that the output controller uses to force the switch off and to restart its initial full-on phase.

Over-current and under-current are reported only while the output controller says the switch conducts: during the initial full-on phase, or during the on part of each PWM period. These faults are not held, so a fault that lasts across PWM operation gives a flag that pulses in step with the PWM waveform. Right after each off-to-on change, under-current is masked for a programmable number of cycles, because an inductive load draws almost no current at first. Over-temperature is handled by a separate latch with hysteresis. It sets when the temperature code reaches a set threshold and releases only after the code falls to a lower clear threshold. While it is set, the flag is low in any mode and shutdown is requested.

Top module: `fault_flag_unit`

## Requirements
- R1: After reset, `fault_n` is 1 and `therm_shdn` is 0.
- R2: With `out_on` held at 1, `oc_raw` rising to 1 makes `fault_n` go to 0 on the third clock edge after the change: two synchronizer flops, then the flag register.
- R3: When `out_on` is 0 and no thermal fault is set, `fault_n` is 1 one edge later, whatever the current comparators show. A lasting current fault therefore makes the flag follow `out_on`, one cycle late.
- R4: Current faults are not held. Once `oc_raw` returns to 0, with no other fault present, `fault_n` returns to 1 on the third edge.
- R5: A synchronized under-current with `out_on` at 1 and the blanking window over drives `fault_n` to 0.
- R6: The blanking window starts in the cycle in which `out_on` is first seen at 1 and lasts `BLANK_CYC` cycles. During it, under-current has no effect on `fault_n`. Over-current is never blanked.
- R7: When `therm_shdn` is 0 and `temp_code` is greater than or equal to `TEMP_SET` at an edge, `therm_shdn` is 1 after that edge.
- R8: While `therm_shdn` is 1 it stays 1 as long as `temp_code` is above `TEMP_CLR`. It goes to 0 on the edge at which `temp_code` is less than or equal to `TEMP_CLR`.
- R9: While `therm_shdn` is 1, `fault_n` is 0 from the next edge on, regardless of `out_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| out_on | input | 1 | Switch-conducting state from the output controller (synchronous) |
| oc_raw | input | 1 | Over-current comparator bit (asynchronous) |
| uc_raw | input | 1 | Under-current comparator bit (asynchronous) |
| temp_code | input | TEMP_W | Die temperature in degrees C, unsigned (synchronous) |
| fault_n | output | 1 | Registered fault flag, 0 means fault |
| therm_shdn | output | 1 | Thermal shutdown request, held with hysteresis |

## Verification
The bench builds the block with `BLANK_CYC` set to 6 rather than the default of 250. This lets it check both the last masked cycle and the first unmasked cycle of the under-current window within a short run. The thermal thresholds keep their defaults of 165 and 150. The bench drives the codes on either side of each threshold (164/165 and 151/150) to test the greater-or-equal and less-or-equal comparisons and the hold band between them.

// File: rtl/fault_flag_pkg.sv
package fault_flag_pkg;
  typedef logic [15:0] tcode_t;

  function automatic logic thermal_next(input logic hot, input tcode_t t,
                                        input tcode_t set_th, input tcode_t clr_th);
    if (hot) return !(t <= clr_th);
    return (t >= set_th);
  endfunction

  function automatic logic current_fault(input logic on, input logic oc,
                                         input logic uc, input logic blank);
    return on && (oc || (uc && !blank));
  endfunction
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/blank_timer.sv
module blank_timer #(
  parameter int BLANK_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic out_on,
  output logic blank
);
  localparam int CW = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;

  if (BLANK_CYC == 0) begin : g_none
    assign blank = 1'b0;
  end else begin : g_cnt
    logic          on_q;
    logic [CW-1:0] cnt;
    logic          rise;
    assign rise = out_on && !on_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        on_q <= 1'b0;
        cnt  <= '0;
      end else begin
        on_q <= out_on;
        if (!out_on)         cnt <= '0;
        else if (rise)       cnt <= CW'(BLANK_CYC - 1);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
    end
    assign blank = rise || (cnt != '0);
  end
endmodule

// File: rtl/thermal_latch.sv
module thermal_latch
  import fault_flag_pkg::*;
#(
  parameter int TEMP_W   = 8,
  parameter int TEMP_SET = 165,
  parameter int TEMP_CLR = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              hot
);
  localparam tcode_t SET_TH = tcode_t'(TEMP_SET);
  localparam tcode_t CLR_TH = tcode_t'(TEMP_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot <= 1'b0;
    else        hot <= thermal_next(hot, tcode_t'(temp_code), SET_TH, CLR_TH);
  end
endmodule

// File: rtl/fault_flag_unit.sv
module fault_flag_unit
  import fault_flag_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int TEMP_SET    = 165,
  parameter int TEMP_CLR    = 150,
  parameter int BLANK_CYC   = 250,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_on,
  input  logic              oc_raw,
  input  logic              uc_raw,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              fault_n,
  output logic              therm_shdn
);
  logic [1:0] cmp_s;
  logic       oc_s, uc_s, blank, cur_flt, hot;

  sync_bank #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({oc_raw, uc_raw}), .q(cmp_s)
  );
  assign oc_s = cmp_s[1];
  assign uc_s = cmp_s[0];

  blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .out_on(out_on), .blank(blank)
  );

  thermal_latch #(.TEMP_W(TEMP_W), .TEMP_SET(TEMP_SET), .TEMP_CLR(TEMP_CLR)) u_therm (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .hot(hot)
  );

  assign cur_flt    = current_fault(out_on, oc_s, uc_s, blank);
  assign therm_shdn = hot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_n <= 1'b1;
    else        fault_n <= !(cur_flt || hot);
  end
endmodule

// File: rtl/fault_flag_chk.sv
module fault_flag_chk #(
  parameter int TEMP_W   = 8,
  parameter int TEMP_SET = 165,
  parameter int TEMP_CLR = 150
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_on,
  input logic              oc_s,
  input logic              uc_s,
  input logic              blank,
  input logic [TEMP_W-1:0] temp_code,
  input logic              fault_n,
  input logic              therm_shdn
);
  // R2
  oc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_on && oc_s) |=> !fault_n);
  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_on && !therm_shdn) |=> fault_n);
  // R6
  blank_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && !oc_s && !therm_shdn) |=> fault_n);
  // R5
  uc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_on && uc_s && !blank) |=> !fault_n);
  // R7
  therm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!therm_shdn && temp_code >= TEMP_W'(TEMP_SET)) |=> therm_shdn);
  // R8
  therm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_shdn && temp_code > TEMP_W'(TEMP_CLR)) |=> therm_shdn);
  // R8
  therm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_shdn && temp_code <= TEMP_W'(TEMP_CLR)) |=> !therm_shdn);
  // R9
  therm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    therm_shdn |=> !fault_n);
endmodule

bind fault_flag_unit fault_flag_chk #(
  .TEMP_W(TEMP_W), .TEMP_SET(TEMP_SET), .TEMP_CLR(TEMP_CLR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_on(out_on), .oc_s(oc_s), .uc_s(uc_s),
  .blank(blank), .temp_code(temp_code), .fault_n(fault_n), .therm_shdn(therm_shdn)
);

// File: tb/fault_flag_unit_test.sv
`timescale 1ns/1ps
module fault_flag_unit_test;
  localparam int BLANK = 6;
  localparam int TSET  = 165;
  localparam int TCLR  = 150;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       out_on = 1'b0, oc_raw = 1'b0, uc_raw = 1'b0;
  logic [7:0] temp_code = 8'd25;
  logic       fault_n, therm_shdn;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  fault_flag_unit #(.TEMP_W(8), .TEMP_SET(TSET), .TEMP_CLR(TCLR),
                    .BLANK_CYC(BLANK), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .out_on(out_on), .oc_raw(oc_raw), .uc_raw(uc_raw),
    .temp_code(temp_code), .fault_n(fault_n), .therm_shdn(therm_shdn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic t_reset();
    check(fault_n, 1'b1, "R1 fault_n after reset");
    check(therm_shdn, 1'b0, "R1 therm_shdn after reset");
  endtask

  task automatic t_overcurrent();
    out_on = 1'b1; tick(2);
    oc_raw = 1'b1;
    tick(2); check(fault_n, 1'b1, "R2 flag not yet low after two edges");
    tick(1); check(fault_n, 1'b0, "R2 flag low on third edge");
    oc_raw = 1'b0;
    tick(2); check(fault_n, 1'b0, "R4 flag still low after two edges");
    tick(1); check(fault_n, 1'b1, "R4 flag released on third edge");
  endtask

  task automatic t_pwm_gating();
    oc_raw = 1'b1; out_on = 1'b1; tick(4);
    check(fault_n, 1'b0, "R2 flag low during on phase");
    for (int p = 0; p < 3; p++) begin
      out_on = 1'b0; tick(1);
      check(fault_n, 1'b1, "R3 flag high in off phase");
      tick(2);
      check(fault_n, 1'b1, "R3 flag stays high in off phase");
      out_on = 1'b1; tick(1);
      check(fault_n, 1'b0, "R6 over-current not blanked after turn-on");
      tick(2);
    end
    oc_raw = 1'b0; out_on = 1'b0; tick(4);
  endtask

  task automatic t_blanking();
    uc_raw = 1'b1; tick(4);
    check(fault_n, 1'b1, "R3 under-current ignored while off");
    out_on = 1'b1;
    tick(BLANK); check(fault_n, 1'b1, "R6 under-current masked through window");
    tick(1);     check(fault_n, 1'b0, "R5 under-current flags after window");
    tick(3);     check(fault_n, 1'b0, "R5 under-current stays flagged");
    out_on = 1'b0; tick(1);
    check(fault_n, 1'b1, "R3 under-current dropped in off phase");
    out_on = 1'b1; tick(2);
    check(fault_n, 1'b1, "R6 window restarts at each turn-on");
    uc_raw = 1'b0; out_on = 1'b0; tick(4);
  endtask

  task automatic t_thermal(input logic on_state);
    out_on = on_state;
    temp_code = 8'(TSET - 1); tick(2);
    check(therm_shdn, 1'b0, "R7 below set threshold no shutdown");
    check(fault_n, 1'b1, "R7 below set threshold flag high");
    temp_code = 8'(TSET); tick(1);
    check(therm_shdn, 1'b1, "R7 shutdown at set threshold");
    tick(1);
    check(fault_n, 1'b0, "R9 flag low during thermal fault");
    temp_code = 8'(TCLR + 1); tick(3);
    check(therm_shdn, 1'b1, "R8 held above clear threshold");
    check(fault_n, 1'b0, "R9 flag stays low while held");
    temp_code = 8'(TCLR); tick(1);
    check(therm_shdn, 1'b0, "R8 released at clear threshold");
    tick(1);
    check(fault_n, 1'b1, "R9 flag high after release");
    temp_code = 8'(TSET - 1); tick(2);
    check(therm_shdn, 1'b0, "R8 no re-set inside hysteresis band");
    temp_code = 8'd25; out_on = 1'b0; tick(3);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_overcurrent();
    t_pwm_gating();
    t_blanking();
    t_thermal(1'b0);
    t_thermal(1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule